// File: doc/BRIEF.md
# Receive Sampling Phase Tuner

This block is the control sequencer that picks the receive sampling phase of a high-speed SD/eMMC host. After a start pulse it looks at the selected bus mode. When the mode needs tuning, it steps a delay-line setting through its whole range. At each setting it first has the delay-line programmer load the phase. It then asks the command engine for one tuning command and records whether that command passed.

While it sweeps, the block keeps track of runs of consecutive passing settings. When the sweep ends, it loads a phase that lies three quarters of the way into the longest run. Two conditions make the result an error: no setting passed, or the sampling-clock-select flag is not set when the sweep ends. On an error the block clears that flag and drops its own delay-line force and software-tune levels. Both outcomes end with a data-line reset and then a command-line reset, and only after that does the block report.

Each handshake to a neighbour uses a request that stays high until the neighbour returns a one-cycle acknowledge. Nothing passes back-pressure. The command engine, the delay-line programmer and the reset logic each set their own pace by delaying their acknowledge. While a request is high, its payload (`dll_phase`) holds still.

Top module: `rx_phase_tuner`

## Requirements
- R1: Bus mode codes: 2 = SDR50, 3 = SDR104, 4 = HS200; any other code needs no tuning. The block tunes on a start pulse in mode 3 or 4, or in mode 2 when `cap_tune_sdr50` is 1. In any other case `done` goes high in the cycle after the start is sampled, with `error` = 0, and no delay-line, command or reset request is made.
- R2: `dll_swt` goes to 1 before the first delay-line request of a tuning run and stays 1 through the whole sweep.
- R3: The sweep visits phases 0, 4, 8, …, 124 in that order, which is 32 trial points. At each point the delay-line request is acknowledged before exactly one command request is raised.
- R4: `dll_req`, `cmd_req`, `rst_dat_req` and `rst_cmd_req` each stay high until they are acknowledged. `dll_phase` is stable while `dll_req` is high. `dll_req` and `cmd_req` are never high together.
- R5: A pass that follows a pass lengthens the current run. A pass that follows a fail, or that comes at the first point, starts a new run of length 1 at that phase. The best run is replaced only by a strictly longer one, so on a tie the earliest run wins.
- R6: On success, one more delay-line request follows the sweep, with phase = best_start + 4 × floor(3 × best_len / 4). After that, `dll_force` and `dll_swt` stay 1.
- R7: If no trial point passed, the run ends with `error` = 1.
- R8: If `sclk_sel` is 0 when the sweep ends, the run ends with `error` = 1 even if some points passed.
- R9: On error, `sclk_clr` pulses for one cycle and both `dll_force` and `dll_swt` return to 0. No final delay-line request is made.
- R10: After every tuning run, whether it succeeds or fails, exactly one data-line reset handshake completes and then exactly one command-line reset handshake, both before `done`.
- R11: `done` is high for exactly one cycle per accepted start. `error` is high only while `done` is high.
- R12: A start pulse that arrives while a run is in progress is ignored: the run still makes 32 trial points and produces one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to tune (pulse) |
| bus_mode | input | 3 | Selected bus mode code |
| cap_tune_sdr50 | input | 1 | SDR50 requires tuning |
| sclk_sel | input | 1 | Sampling-clock-select flag, sampled at the end of the sweep |
| sclk_clr | output | 1 | One-cycle pulse that clears the sampling-clock-select flag |
| dll_req | output | 1 | Delay-line load request |
| dll_phase | output | 7 | Phase to load |
| dll_ack | input | 1 | Delay-line load acknowledge |
| dll_force | output | 1 | Forced-value level for the delay line |
| dll_swt | output | 1 | Software-tune enable level |
| cmd_req | output | 1 | Tuning command request |
| cmd_done | input | 1 | Tuning command finished |
| cmd_ok | input | 1 | Command passed; valid with `cmd_done` |
| rst_dat_req | output | 1 | Data-line reset request |
| rst_dat_ack | input | 1 | Data-line reset finished |
| rst_cmd_req | output | 1 | Command-line reset request |
| rst_cmd_ack | input | 1 | Command-line reset finished |
| done | output | 1 | Run finished (one cycle) |
| error | output | 1 | Run failed; valid with `done` |

## Verification
Two functions meet in the cycle that handles the last trial point: the run-length update for phase 124 and the end-of-sweep decision. A window that ends at 124 only becomes the best run in that same step, so the final phase depends on both landing correctly. The bench provokes this with single windows swept over many start and length pairs, with an all-pass pattern and with a lone pass at 124, and judges each by the phase of the final delay-line request and the error flag. A second collision comes from a stray start pulse injected mid-sweep; it is judged by the count of trial points and of `done` pulses.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  localparam logic [2:0] MODE_SDR50  = 3'd2;
  localparam logic [2:0] MODE_SDR104 = 3'd3;
  localparam logic [2:0] MODE_HS200  = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SWT,
    ST_TRY_DLL,
    ST_TRY_CMD,
    ST_EVAL,
    ST_CLEAN,
    ST_FIX_DLL,
    ST_RST_DAT,
    ST_RST_CMD,
    ST_FIN
  } tune_st_e;
endpackage

// File: rtl/tune_run_tracker.sv
module tune_run_tracker #(
  parameter int PHASE_W = 7,
  parameter int LEN_W   = 6,
  parameter int TRIALS  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rec,
  input  logic               hit,
  input  logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] best_start,
  output logic [LEN_W-1:0]   best_len
);
  logic               prev_q;
  logic [LEN_W-1:0]   run_len_q, nxt_len;
  logic [PHASE_W-1:0] run_start_q, nxt_start;

  always_comb begin
    nxt_len   = run_len_q;
    nxt_start = run_start_q;
    if (hit) begin
      if (prev_q) begin
        nxt_len = run_len_q + LEN_W'(1);
      end else begin
        nxt_len   = LEN_W'(1);
        nxt_start = phase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      run_len_q   <= '0;
      run_start_q <= '0;
      best_len    <= '0;
      best_start  <= '0;
    end else if (clr) begin
      prev_q      <= 1'b0;
      run_len_q   <= '0;
      run_start_q <= '0;
      best_len    <= '0;
      best_start  <= '0;
    end else if (rec) begin
      prev_q      <= hit;
      run_len_q   <= nxt_len;
      run_start_q <= nxt_start;
      if (nxt_len > best_len) begin
        best_len   <= nxt_len;
        best_start <= nxt_start;
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len_q <= LEN_W'(TRIALS)); // R5
  AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_len >= $past(best_len)); // R5
  AST_NEW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && hit && !prev_q && !clr) |=> run_len_q == LEN_W'(1)); // R5
endmodule

// File: rtl/tune_phase_pick.sv
module tune_phase_pick #(
  parameter int PHASE_W = 7,
  parameter int LEN_W   = 6,
  parameter int STEP    = 4
) (
  input  logic [PHASE_W-1:0] best_start,
  input  logic [LEN_W-1:0]   best_len,
  output logic [PHASE_W-1:0] pick
);
  logic [LEN_W+1:0] triple;
  logic [LEN_W-1:0] quarter;

  always_comb begin
    triple  = {2'b00, best_len} + {1'b0, best_len, 1'b0};
    quarter = triple[LEN_W+1:2];
    pick    = best_start + PHASE_W'(int'(quarter) * STEP);
  end
endmodule

// File: rtl/rx_phase_tuner.sv
module rx_phase_tuner
  import phase_tune_pkg::*;
#(
  parameter int PHASE_W = 7,
  parameter int STEP    = 4,
  parameter int TRIALS  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         bus_mode,
  input  logic               cap_tune_sdr50,
  input  logic               sclk_sel,
  output logic               sclk_clr,
  output logic               dll_req,
  output logic [PHASE_W-1:0] dll_phase,
  input  logic               dll_ack,
  output logic               dll_force,
  output logic               dll_swt,
  output logic               cmd_req,
  input  logic               cmd_done,
  input  logic               cmd_ok,
  output logic               rst_dat_req,
  input  logic               rst_dat_ack,
  output logic               rst_cmd_req,
  input  logic               rst_cmd_ack,
  output logic               done,
  output logic               error
);
  localparam int LEN_W = $clog2(TRIALS + 1);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(STEP * (TRIALS - 1));

  tune_st_e           st_q;
  logic [PHASE_W-1:0] phase_q, best_start, pick;
  logic [LEN_W-1:0]   best_len;
  logic               err_q, swt_q, force_q, need_tune, rec, trk_clr;

  assign need_tune = (bus_mode == MODE_HS200) || (bus_mode == MODE_SDR104) ||
                     ((bus_mode == MODE_SDR50) && cap_tune_sdr50);
  assign rec     = (st_q == ST_TRY_CMD) && cmd_done;
  assign trk_clr = (st_q == ST_SWT);

  tune_run_tracker #(.PHASE_W(PHASE_W), .LEN_W(LEN_W), .TRIALS(TRIALS)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .rec(rec), .hit(cmd_ok),
    .phase(phase_q), .best_start(best_start), .best_len(best_len)
  );

  tune_phase_pick #(.PHASE_W(PHASE_W), .LEN_W(LEN_W), .STEP(STEP)) u_pick (
    .best_start(best_start), .best_len(best_len), .pick(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      err_q   <= 1'b0;
      swt_q   <= 1'b0;
      force_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          err_q <= 1'b0;
          st_q  <= need_tune ? ST_SWT : ST_FIN;
        end
        ST_SWT: begin
          swt_q   <= 1'b1;
          phase_q <= '0;
          st_q    <= ST_TRY_DLL;
        end
        ST_TRY_DLL: if (dll_ack) begin
          force_q <= 1'b1;
          st_q    <= ST_TRY_CMD;
        end
        ST_TRY_CMD: if (cmd_done) begin
          if (phase_q == PHASE_LAST) begin
            st_q <= ST_EVAL;
          end else begin
            phase_q <= phase_q + PHASE_W'(STEP);
            st_q    <= ST_TRY_DLL;
          end
        end
        ST_EVAL: begin
          if (best_len == '0 || !sclk_sel) begin
            err_q <= 1'b1;
            st_q  <= ST_CLEAN;
          end else begin
            st_q  <= ST_FIX_DLL;
          end
        end
        ST_CLEAN: begin
          swt_q   <= 1'b0;
          force_q <= 1'b0;
          st_q    <= ST_RST_DAT;
        end
        ST_FIX_DLL: if (dll_ack) st_q <= ST_RST_DAT;
        ST_RST_DAT: if (rst_dat_ack) st_q <= ST_RST_CMD;
        ST_RST_CMD: if (rst_cmd_ack) st_q <= ST_FIN;
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dll_req     = (st_q == ST_TRY_DLL) || (st_q == ST_FIX_DLL);
  assign dll_phase   = (st_q == ST_FIX_DLL) ? pick : phase_q;
  assign cmd_req     = (st_q == ST_TRY_CMD);
  assign rst_dat_req = (st_q == ST_RST_DAT);
  assign rst_cmd_req = (st_q == ST_RST_CMD);
  assign sclk_clr    = (st_q == ST_CLEAN);
  assign dll_force   = force_q;
  assign dll_swt     = swt_q;
  assign done        = (st_q == ST_FIN);
  assign error       = done && err_q;

  AST_DLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_req && !dll_ack) |=> (dll_req && $stable(dll_phase))); // R4
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> cmd_req); // R4
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dll_req && cmd_req)); // R4
  AST_CMD_AFTER_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req) |-> $past(dll_ack)); // R3
  AST_SWT_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> dll_swt); // R2
  AST_CLEAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_clr |=> (!dll_swt && !dll_force)); // R9
  AST_RST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_cmd_req) |-> $past(rst_dat_ack)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R11
endmodule

// File: tb/sim_rx_phase_tuner.sv
module sim_rx_phase_tuner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] bus_mode = 3'd0;
  logic cap_tune_sdr50 = 1'b0;
  logic sclk_sel = 1'b1;
  logic sclk_clr, dll_req, dll_force, dll_swt, cmd_req, rst_dat_req, rst_cmd_req, done, error;
  logic [6:0] dll_phase;
  logic dll_ack = 1'b0, cmd_done = 1'b0, cmd_ok = 1'b0, rst_dat_ack = 1'b0, rst_cmd_ack = 1'b0;

  always #4 clk = ~clk;

  rx_phase_tuner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_mode(bus_mode),
    .cap_tune_sdr50(cap_tune_sdr50), .sclk_sel(sclk_sel), .sclk_clr(sclk_clr),
    .dll_req(dll_req), .dll_phase(dll_phase), .dll_ack(dll_ack),
    .dll_force(dll_force), .dll_swt(dll_swt), .cmd_req(cmd_req),
    .cmd_done(cmd_done), .cmd_ok(cmd_ok), .rst_dat_req(rst_dat_req),
    .rst_dat_ack(rst_dat_ack), .rst_cmd_req(rst_cmd_req),
    .rst_cmd_ack(rst_cmd_ack), .done(done), .error(error)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] pat = '0;
  int lat = 0;
  int dll_n = 0, cmd_n = 0, dat_n = 0, rcm_n = 0, done_n = 0, clr_n = 0, cyc = 0;
  int dat_at = 0, rcm_at = 0, done_at = 0;
  int dll_log [0:63];
  logic swt_at_first = 1'b0, err_seen = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // delay-line programmer
  initial forever begin
    int w = 0;
    @(negedge clk);
    if (dll_ack) dll_ack = 1'b0;
    else if (dll_req) begin
      if (w >= lat) begin
        if (dll_n == 0) swt_at_first = dll_swt;
        if (dll_n < 64) dll_log[dll_n] = int'(dll_phase);
        dll_n++;
        dll_ack = 1'b1;
        w = 0;
      end else w++;
    end
  end

  // command engine
  initial forever begin
    int w = 0;
    @(negedge clk);
    if (cmd_done) cmd_done = 1'b0;
    else if (cmd_req) begin
      if (w >= lat + 1) begin
        cmd_ok = (cmd_n < 32) ? pat[cmd_n] : 1'b0;
        cmd_n++;
        cmd_done = 1'b1;
        w = 0;
      end else w++;
    end
  end

  // line reset responders and output monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_dat_ack) rst_dat_ack = 1'b0;
    else if (rst_dat_req) begin rst_dat_ack = 1'b1; dat_n++; dat_at = cyc; end
    if (rst_cmd_ack) rst_cmd_ack = 1'b0;
    else if (rst_cmd_req) begin rst_cmd_ack = 1'b1; rcm_n++; rcm_at = cyc; end
    if (sclk_clr) clr_n++;
    if (done) begin done_n++; done_at = cyc; err_seen = error; end
    if (error && !done) chk(1'b0, "R11 error outside done", 1, 0);
  end

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_case(input logic [2:0] m, input logic c, input logic [31:0] p,
                          input logic s, input int l, input logic poke);
    logic tune;
    int best, bs, fin, k;
    logic expe, ok;
    dll_n = 0; cmd_n = 0; dat_n = 0; rcm_n = 0; done_n = 0; clr_n = 0;
    swt_at_first = 1'b0;
    pat = p; sclk_sel = s; bus_mode = m; cap_tune_sdr50 = c; lat = l;
    tune = (m == 3'd3) || (m == 3'd4) || ((m == 3'd2) && c);
    @(negedge clk); start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (!tune) begin
      chk(done_n == 1, "R1 done one cycle after start", done_n, 1);
      repeat (4) @(negedge clk);
      #1;
      chk(dll_n == 0 && cmd_n == 0 && dat_n == 0 && rcm_n == 0, "R1 no requests",
          dll_n + cmd_n + dat_n + rcm_n, 0);
      chk(err_seen == 1'b0, "R1 error low", int'(err_seen), 0);
      chk(done_n == 1, "R11 single done", done_n, 1);
      return;
    end
    k = 0;
    while (done_n == 0 && k < 3000) begin
      @(negedge clk); #1;
      k++;
      if (poke && k == 40) start = 1'b1;
      if (poke && k == 41) start = 1'b0;
    end
    repeat (4) @(negedge clk);
    #1;
    best = 0; bs = 0;
    for (int i = 0; i < 32; i++) begin
      if (p[i] && (i == 0 || !p[i-1])) begin
        int len = 0;
        while (i + len < 32 && p[i+len]) len++;
        if (len > best) begin best = len; bs = 4 * i; end
      end
    end
    fin = bs + 4 * ((3 * best) / 4);
    expe = (best == 0) || !s;
    chk(done_n == 1, "R11/R12 one done per run", done_n, 1);
    chk(cmd_n == 32, "R3/R12 trial count", cmd_n, 32);
    ok = 1'b1;
    for (int i = 0; i < 32; i++) if (dll_log[i] != 4 * i) ok = 1'b0;
    chk(ok, "R3 sweep phase order", dll_log[1], 4);
    chk(swt_at_first == 1'b1, "R2 swt before first load", int'(swt_at_first), 1);
    chk(err_seen == expe, (best == 0) ? "R7 no-match error" : "R8/R5 error flag",
        int'(err_seen), int'(expe));
    chk(dat_n == 1 && rcm_n == 1 && dat_at < rcm_at && rcm_at < done_at,
        "R10 reset order", rcm_at - dat_at, 1);
    if (expe) begin
      chk(dll_n == 32, "R9 no final load", dll_n, 32);
      chk(clr_n == 1, "R9 sclk_clr pulse", clr_n, 1);
      chk(!dll_force && !dll_swt, "R9 levels dropped", int'(dll_force) + int'(dll_swt), 0);
    end else begin
      chk(dll_n == 33, "R6 final load issued", dll_n, 33);
      chk(dll_log[32] == fin, "R6/R5 final phase", dll_log[32], fin);
      chk(dll_force && dll_swt && clr_n == 0, "R6 levels kept", int'(dll_force) + int'(dll_swt), 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !error && !dll_req && !cmd_req && !rst_dat_req && !rst_cmd_req &&
        !dll_swt && !dll_force && !sclk_clr, "R11 reset state", int'(done), 0);
    rst_n = 1'b1;
    // R1 gating over every mode code
    for (int m = 0; m < 8; m++) begin
      run_case(3'(m), 1'b0, 32'h0000_FF00, 1'b1, 0, 1'b0);
      run_case(3'(m), 1'b1, 32'h0000_FF00, 1'b1, 1, 1'b0);
    end
    run_case(3'd4, 1'b0, 32'h0,         1'b1, 0, 1'b0); // R7
    run_case(3'd3, 1'b0, 32'hFFFF_FFFF, 1'b1, 2, 1'b0); // R6 all pass
    run_case(3'd4, 1'b0, 32'h8000_0000, 1'b1, 0, 1'b0); // R5 lone pass at 124
    run_case(3'd4, 1'b0, 32'h00F0_00F0, 1'b1, 1, 1'b0); // R5 tie, earliest wins
    run_case(3'd4, 1'b0, 32'h5555_5555, 1'b1, 0, 1'b0); // R5 alternating
    run_case(3'd3, 1'b0, 32'h00FF_0000, 1'b0, 0, 1'b0); // R8 flag clear
    run_case(3'd2, 1'b1, 32'h0FF0_0000, 1'b1, 1, 1'b1); // R12 stray start
    // R5/R6 single windows across start and length
    for (int s = 0; s < 32; s += 3)
      for (int l = 1; s + l <= 32; l++)
        run_case(3'd4, 1'b0, ((32'h1 << l) - 32'h1) << s | ((l == 32) ? 32'hFFFF_FFFF : 32'h0),
                 1'b1, 0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule